// File: doc/BRIEF.md
# Multi-Channel One-Shot Pulse Generator

This block holds three independent pulse channels. Each one turns an asynchronous trigger input into a single pulse on its output. The length of the pulse comes from a period value that the host loads. A channel reacts to a trigger only while it is armed. The host arms a channel with a command strobe. The armed flags of all channels are visible in a status word, so software can tell which channels still accept a trigger.

Each channel has a mode input that selects one of two behaviours:
- **Single-fire:** the channel disarms itself when its pulse ends, and ignores triggers that arrive while the pulse is running.
- **Retriggerable:** the channel stays armed, and a trigger during a pulse restarts the count, which stretches the pulse.

Loading a new period always disarms the channel, so software must arm the channel again after it changes the period. A synchronous timer-clear input disarms every channel and stops every pulse.

Top module: `oneshot_trig_ctrl`

## Requirements
- R1: There are three channels and they are independent. Status bit n (n = 0, 1, 2) is the armed flag of channel n. Status bit 3 always reads 0. Arming or triggering one channel never changes the flag or the pulse of another channel.
- R2: After `rst_n` is low, and in the cycle after `timer_clr` is high, every armed flag is 0 and every pulse output is low.
- R3: A high `arm_cmd[n]` in a cycle without `period_load[n]` and without `timer_clr` makes status bit n equal 1 in the next cycle.
- R4: Take a rising edge on `trig_in[n]` of an armed channel with a non-zero period P, sent from the negative edge before clock edge 1. The pulse output `pulse_out[n]` is high after clock edge 3 and stays high for exactly P cycles.
- R5: While status bit n is 0, rising edges on `trig_in[n]` produce no pulse.
- R6: In single-fire mode (`retrig_mode[n]` = 0), the armed flag clears on the clock edge where the pulse ends. Trigger edges that arrive while the pulse is high are ignored.
- R7: In retriggerable mode (`retrig_mode[n]` = 1), the armed flag stays at 1 after the pulse ends. A trigger edge during a pulse reloads the count to P, so the pulse stays high until P cycles after that reload.
- R8: A high `period_load[n]` clears status bit n in the next cycle. This holds even when `arm_cmd[n]` is high in the same cycle.
- R9: An armed channel with a period of 0 produces no pulse on a trigger, and its armed flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| timer_clr | input | 1 | Synchronous clear: disarms all channels and stops all pulses |
| arm_cmd | input | 3 | Per-channel arm command strobe |
| period_load | input | 3 | Per-channel period load strobe |
| period_val | input | 48 | Period values. Channel n uses bits [16n+15:16n] |
| retrig_mode | input | 3 | Per-channel mode: 1 = retriggerable, 0 = single-fire |
| trig_in | input | 3 | Asynchronous trigger inputs |
| pulse_out | output | 3 | One-shot pulse outputs |
| status_word | output | 4 | Armed flags in bits 2:0. Bit 3 is 0 |

## Verification
A stuck or wrong armed flag shows up on `status_word` one cycle after the command that should have changed it. A bad down-counter shows up on `pulse_out`:
- A load that is missing or wrong makes the pulse the wrong length.
- A reload that is lost in retriggerable mode makes the pulse too short.
- A disarm that is missing in single-fire mode makes a later trigger produce a pulse. That pulse appears three cycles after the trigger input rises.

Errors in the synchroniser show up as a pulse that starts at the wrong cycle.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
   typedef enum logic {
      MODE_SINGLE  = 1'b0,
      MODE_RETRIG  = 1'b1
   } os_mode_e;

   // next value of a channel down-counter
   function automatic logic [31:0] next_count(
      input logic        clr,
      input logic        accept,
      input logic [31:0] cur,
      input logic [31:0] period
   );
      if (clr)              return '0;
      else if (accept)      return period;
      else if (cur != '0)   return cur - 32'd1;
      else                  return '0;
   endfunction
endpackage

// File: rtl/oneshot_sync_edge.sv
module oneshot_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic din,
   output logic rise
);
   logic level;
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign level = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sh_q <= '0;
            else if (clr) sh_q <= '0;
            else          sh_q <= (sh_q << 1) | STAGES'(din);
         end
         assign level = sh_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev_q <= 1'b0;
      else if (clr) prev_q <= 1'b0;
      else          prev_q <= level;
   end

   assign rise = level & ~prev_q;
endmodule

// File: rtl/oneshot_channel.sv
module oneshot_channel
   import oneshot_pkg::*;
#(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                arm_cmd,
   input  logic                period_load,
   input  logic [PERIOD_W-1:0] period_val,
   input  logic                retrig,
   input  logic                trig_rise,
   output logic                armed,
   output logic                pulse
);
   logic [PERIOD_W-1:0] period_q;
   logic [PERIOD_W-1:0] count_q;
   logic                armed_q;
   logic                accept;
   logic                done;
   os_mode_e            mode;
   logic [31:0]         cnt_next;

   assign mode   = retrig ? MODE_RETRIG : MODE_SINGLE;
   assign accept = armed_q & trig_rise & (period_q != '0) &
                   ((mode == MODE_RETRIG) | (count_q == '0));
   assign done   = (count_q == PERIOD_W'(1)) & ~accept;
   assign cnt_next = next_count(clr, accept, 32'(count_q), 32'(period_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         count_q  <= '0;
         armed_q  <= 1'b0;
      end else begin
         count_q <= cnt_next[PERIOD_W-1:0];
         if (clr)              period_q <= '0;
         else if (period_load) period_q <= period_val;
         if (clr || period_load)                 armed_q <= 1'b0;
         else if (arm_cmd)                       armed_q <= 1'b1;
         else if (done && mode == MODE_SINGLE)   armed_q <= 1'b0;
      end
   end

   assign armed = armed_q;
   assign pulse = (count_q != '0);
endmodule

// File: rtl/oneshot_trig_ctrl.sv
module oneshot_trig_ctrl #(
   parameter int NUM_CH      = 3,
   parameter int PERIOD_W    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int STATUS_W    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       timer_clr,
   input  logic [NUM_CH-1:0]          arm_cmd,
   input  logic [NUM_CH-1:0]          period_load,
   input  logic [NUM_CH*PERIOD_W-1:0] period_val,
   input  logic [NUM_CH-1:0]          retrig_mode,
   input  logic [NUM_CH-1:0]          trig_in,
   output logic [NUM_CH-1:0]          pulse_out,
   output logic [STATUS_W-1:0]        status_word
);
   localparam int PAD_W = STATUS_W - NUM_CH;

   initial begin
      assert (NUM_CH >= 1 && NUM_CH < STATUS_W)
         else $error("NUM_CH must be 1..STATUS_W-1");
      assert (PERIOD_W >= 1 && PERIOD_W <= 32)
         else $error("PERIOD_W must be 1..32");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES must be 0..4");
   end

   logic [NUM_CH-1:0] rise;
   logic [NUM_CH-1:0] armed;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         oneshot_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (timer_clr),
            .din   (trig_in[c]),
            .rise  (rise[c])
         );
         oneshot_channel #(.PERIOD_W(PERIOD_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .clr         (timer_clr),
            .arm_cmd     (arm_cmd[c]),
            .period_load (period_load[c]),
            .period_val  (period_val[c*PERIOD_W +: PERIOD_W]),
            .retrig      (retrig_mode[c]),
            .trig_rise   (rise[c]),
            .armed       (armed[c]),
            .pulse       (pulse_out[c])
         );
      end
   endgenerate

   assign status_word = {{PAD_W{1'b0}}, armed};
endmodule

// File: rtl/oneshot_trig_ctrl_chk.sv
module oneshot_trig_ctrl_chk #(
   parameter int NUM_CH      = 3,
   parameter int PERIOD_W    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int STATUS_W    = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       timer_clr,
   input logic [NUM_CH-1:0]          arm_cmd,
   input logic [NUM_CH-1:0]          period_load,
   input logic [NUM_CH*PERIOD_W-1:0] period_val,
   input logic [NUM_CH-1:0]          retrig_mode,
   input logic [NUM_CH-1:0]          trig_in,
   input logic [NUM_CH-1:0]          pulse_out,
   input logic [STATUS_W-1:0]        status_word
);
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_p
         assert_clr_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
            timer_clr |=> (!status_word[i] && !pulse_out[i]));
         assert_arm_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_cmd[i] && !period_load[i] && !timer_clr) |=> status_word[i]);
         assert_start_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulse_out[i]) |-> $past(status_word[i]));
         assert_single_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pulse_out[i]) && !$past(retrig_mode[i]) && !$past(arm_cmd[i]))
            |-> !status_word[i]);
         assert_retrig_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pulse_out[i]) && $past(retrig_mode[i]) && $past(status_word[i]) &&
             !$past(timer_clr) && !$past(period_load[i])) |-> status_word[i]);
         assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            period_load[i] |=> !status_word[i]);
      end
   endgenerate
endmodule

bind oneshot_trig_ctrl oneshot_trig_ctrl_chk #(
   .NUM_CH(NUM_CH), .PERIOD_W(PERIOD_W),
   .SYNC_STAGES(SYNC_STAGES), .STATUS_W(STATUS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .timer_clr(timer_clr), .arm_cmd(arm_cmd),
   .period_load(period_load), .period_val(period_val), .retrig_mode(retrig_mode),
   .trig_in(trig_in), .pulse_out(pulse_out), .status_word(status_word)
);

// File: tb/oneshot_trig_ctrl_bench.sv
`timescale 1ns/1ps
module oneshot_trig_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        timer_clr = 1'b0;
   logic [2:0]  arm_cmd = '0;
   logic [2:0]  period_load = '0;
   logic [47:0] period_val = '0;
   logic [2:0]  retrig_mode = '0;
   logic [2:0]  trig_in = '0;
   logic [2:0]  pulse_out;
   logic [3:0]  status_word;
   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   oneshot_trig_ctrl u_oneshot_trig_ctrl (
      .clk(clk), .rst_n(rst_n), .timer_clr(timer_clr), .arm_cmd(arm_cmd),
      .period_load(period_load), .period_val(period_val), .retrig_mode(retrig_mode),
      .trig_in(trig_in), .pulse_out(pulse_out), .status_word(status_word)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load(input int ch, input int val);
      @(negedge clk);
      period_val[ch*16 +: 16] = 16'(val);
      period_load[ch] = 1'b1;
      @(negedge clk);
      period_load[ch] = 1'b0;
   endtask

   task automatic arm(input int ch);
      @(negedge clk);
      arm_cmd[ch] = 1'b1;
      @(negedge clk);
      arm_cmd[ch] = 1'b0;
   endtask

   // trigger at t=0, optional second trigger at t=second; sample each negedge
   task automatic profile(input int ch, input int second, input int win,
                          output int first, output int width);
      first = -1; width = 0;
      @(negedge clk);
      trig_in[ch] = 1'b1;
      for (int k = 1; k <= win; k++) begin
         @(negedge clk);
         if (pulse_out[ch]) begin
            if (first < 0) first = k;
            width++;
         end
         if (k == 1) trig_in[ch] = 1'b0;
         if (second > 0 && k == second) trig_in[ch] = 1'b1;
         if (second > 0 && k == second + 1) trig_in[ch] = 1'b0;
      end
   endtask

   task automatic t_reset;
      chk("R2 status after reset", status_word, 0);
      chk("R2 pulses after reset", pulse_out, 0);
   endtask

   task automatic t_single_fire;
      int f, w;
      retrig_mode = 3'b100;
      load(0, 5);
      arm(0);
      chk("R3 arm sets bit0", status_word, 4'b0001);
      chk("R1 bit3 reads zero", status_word[3], 0);
      profile(0, 0, 12, f, w);
      chk("R4 pulse start cycle", f, 3);
      chk("R4 pulse width", w, 5);
      chk("R6 single-fire disarms", status_word[0], 0);
   endtask

   task automatic t_unarmed;
      int f, w;
      profile(0, 0, 12, f, w);
      chk("R5 unarmed trigger ignored", w, 0);
   endtask

   task automatic t_single_ignore;
      int f, w;
      load(1, 6);
      arm(1);
      profile(1, 3, 16, f, w);
      chk("R6 start", f, 3);
      chk("R6 trigger during pulse ignored", w, 6);
   endtask

   task automatic t_retrig;
      int f, w;
      load(2, 6);
      arm(2);
      profile(2, 3, 16, f, w);
      chk("R7 start", f, 3);
      chk("R7 retrigger extends pulse", w, 9);
      chk("R7 stays armed", status_word[2], 1);
   endtask

   task automatic t_load_clears;
      int f, w;
      load(2, 4);
      chk("R8 load clears armed flag", status_word[2], 0);
      @(negedge clk);
      period_val[15:0] = 16'd4;
      period_load[0] = 1'b1;
      arm_cmd[0] = 1'b1;
      @(negedge clk);
      period_load[0] = 1'b0;
      arm_cmd[0] = 1'b0;
      chk("R8 load wins over arm", status_word[0], 0);
      profile(0, 0, 10, f, w);
      chk("R8 no pulse after load+arm", w, 0);
   endtask

   task automatic t_zero;
      int f, w;
      load(1, 0);
      arm(1);
      profile(1, 0, 10, f, w);
      chk("R9 zero period no pulse", w, 0);
      chk("R9 flag kept", status_word[1], 1);
   endtask

   task automatic t_clear;
      load(0, 20);
      arm(0);
      arm(2);
      @(negedge clk);
      trig_in[0] = 1'b1;
      repeat (5) @(negedge clk);
      chk("R2 pulse running before clear", pulse_out[0], 1);
      timer_clr = 1'b1;
      @(negedge clk);
      timer_clr = 1'b0;
      trig_in[0] = 1'b0;
      chk("R2 timer clear status", status_word, 0);
      chk("R2 timer clear pulses", pulse_out, 0);
   endtask

   task automatic t_independent;
      int w[3];
      retrig_mode = 3'b000;
      for (int c = 0; c < 3; c++) load(c, 4);
      arm(1);
      chk("R1 only ch1 armed", status_word, 4'b0010);
      w = '{0, 0, 0};
      @(negedge clk);
      trig_in = 3'b111;
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         for (int c = 0; c < 3; c++) if (pulse_out[c]) w[c]++;
         if (k == 1) trig_in = 3'b000;
      end
      chk("R1 ch0 independent", w[0], 0);
      chk("R1 ch1 pulses", w[1], 4);
      chk("R1 ch2 independent", w[2], 0);
   endtask

   initial begin
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_single_fire();
      t_unarmed();
      t_single_ignore();
      t_retrig();
      t_load_clears();
      t_zero();
      t_clear();
      t_independent();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule